// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block holds a bank of mutual-exclusion registers that the cores of a cluster share to guard common resources such as a serial device or a shared table. Each core has its own request port into the bank, so the port index is the requester's identity. To take a semaphore a core writes its own core ID into that semaphore's register and then reads the register back. The write only succeeds while the register is free. If the readback returns the core's own ID, the core holds the semaphore.

A register that holds all ones is free. Writing all ones to a held register frees it again, and any port may do this. When several ports try to take the same free semaphore in one clock cycle, the port with the lowest index wins. Reads return the register contents from before any write in the same cycle. The response is registered and appears one cycle after the read request.

Top module: `sem_bank`

## Requirements
- R1: Semaphore n (0 to NUM_SEM-1, default 32) sits at byte address BASE_ADDR + 4*n, with BASE_ADDR = 0x80 by default. A read of that address returns the register contents as they stood before any write in the same cycle.
- R2: After reset every semaphore reads back as 0xFFFFFFFF (free), and no read response is pending.
- R3: A write of any value other than 0xFFFFFFFF to a free semaphore stores that value from the next cycle on.
- R4: While a semaphore holds a value other than 0xFFFFFFFF, writes of any other value leave it unchanged.
- R5: A write of 0xFFFFFFFF to a held semaphore frees it. The port that writes it need not be the owner.
- R6: When several ports write non-all-ones values to the same free semaphore in one cycle, the value from the lowest-numbered port is stored and the others are dropped.
- R7: In a cycle where a held semaphore gets both a release write and an acquire write, it ends up free.
- R8: An access whose address is below BASE_ADDR, at or above BASE_ADDR + 4*NUM_SEM, or has bits [1:0] not equal to zero changes no semaphore. A read of such an address returns 0.
- R9: rsp_valid[p] is high in the cycle after port p issues a read (req_valid=1, req_write=0) and low in every other cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-port access request |
| req_write | input | NUM_CORES | Per-port access type: 1 = write, 0 = read |
| req_addr | input | NUM_CORES x ADDR_W | Per-port byte address |
| req_wdata | input | NUM_CORES x 32 | Per-port write data (core ID, or all ones to release) |
| rsp_valid | output | NUM_CORES | Per-port read response strobe, one cycle after the read |
| rsp_rdata | output | NUM_CORES x 32 | Per-port read data |

## Verification
The bench first runs directed cases:
- a lone acquire, which separates a stored value from a dropped one;
- a non-owner acquire on a held register, which shows whether writes to held registers are ignored;
- a release by a port that is not the owner;
- three ports acquiring at once with a read in the same cycle, which tells lowest-index priority from any other order and shows old-versus-new readback;
- a release and an acquire colliding on a held register;
- accesses just outside the window and one unaligned access next to semaphore 0.

A long random phase then follows. It aims most accesses at eight semaphores to force contention, and mixes three kinds of write data: all ones, the writer's own ID and foreign IDs. Every read is compared against a bench model.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Register value meaning "nobody holds this semaphore"
    localparam word_t FREE_VAL = '1;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_bank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_SEM   = 32,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned BASE_ADDR = 32'h80
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output logic              wr_hit,
    output logic              wr_release,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W:0]   SPAN_L = (ADDR_W+1)'(NUM_SEM * 4);

    logic [ADDR_W-1:0] offs;
    logic              in_win;

    always_comb begin
        offs       = addr - BASE_L;
        in_win     = (addr >= BASE_L) && ({1'b0, offs} < SPAN_L) && (offs[1:0] == 2'b00);
        idx        = offs[IDX_W+1:2];
        wr_hit     = valid && write && in_win;
        wr_release = wr_hit && (wdata == FREE_VAL);
        rd_hit     = valid && !write && in_win;
    end

endmodule

// File: rtl/sem_slot_next.sv
module sem_slot_next
    import sem_bank_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned SLOT      = 0
) (
    input  word_t                                 cur,
    input  logic  [NUM_CORES-1:0]                 wr_hit,
    input  logic  [NUM_CORES-1:0]                 wr_release,
    input  logic  [NUM_CORES-1:0][IDX_W-1:0]      idx,
    input  word_t [NUM_CORES-1:0]                 wdata,
    output word_t                                 nxt
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT);

    logic                 found;
    logic [NUM_CORES-1:0] mine;

    always_comb begin
        nxt   = cur;
        found = 1'b0;
        for (int p = 0; p < NUM_CORES; p++) begin
            mine[p] = wr_hit[p] && (idx[p] == MY_IDX);
        end
        if (cur == FREE_VAL) begin
            // free: lowest-numbered acquiring port takes it
            for (int p = 0; p < NUM_CORES; p++) begin
                if (!found && mine[p] && !wr_release[p]) begin
                    nxt   = wdata[p];
                    found = 1'b1;
                end
            end
        end else begin
            // held: only an all-ones write changes it
            for (int p = 0; p < NUM_CORES; p++) begin
                if (mine[p] && wr_release[p]) begin
                    nxt = FREE_VAL;
                end
            end
        end
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NUM_SEM   = 32,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h80
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CORES-1:0]             req_valid,
    input  logic [NUM_CORES-1:0]             req_write,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES-1:0][31:0]       req_wdata,
    output logic [NUM_CORES-1:0]             rsp_valid,
    output logic [NUM_CORES-1:0][31:0]       rsp_rdata
);

    localparam int unsigned IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

    typedef struct packed {
        word_t [NUM_SEM-1:0]   slots;
        logic  [NUM_CORES-1:0] rvld;
        word_t [NUM_CORES-1:0] rdat;
    } state_t;

    state_t st_d, st_q;

    logic  [NUM_CORES-1:0]            wr_hit;
    logic  [NUM_CORES-1:0]            wr_rel;
    logic  [NUM_CORES-1:0]            rd_hit;
    logic  [NUM_CORES-1:0][IDX_W-1:0] pidx;
    word_t [NUM_CORES-1:0]            wdat;
    word_t [NUM_SEM-1:0]              slot_nxt;
    word_t [NUM_SEM-1:0]              slots_q;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        assign wdat[p] = req_wdata[p];
        sem_port_decode #(
            .ADDR_W   (ADDR_W),
            .NUM_SEM  (NUM_SEM),
            .IDX_W    (IDX_W),
            .BASE_ADDR(BASE_ADDR)
        ) u_dec (
            .valid     (req_valid[p]),
            .write     (req_write[p]),
            .addr      (req_addr[p]),
            .wdata     (wdat[p]),
            .wr_hit    (wr_hit[p]),
            .wr_release(wr_rel[p]),
            .rd_hit    (rd_hit[p]),
            .idx       (pidx[p])
        );
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_slot
        sem_slot_next #(
            .NUM_CORES(NUM_CORES),
            .IDX_W    (IDX_W),
            .SLOT     (s)
        ) u_next (
            .cur       (st_q.slots[s]),
            .wr_hit    (wr_hit),
            .wr_release(wr_rel),
            .idx       (pidx),
            .wdata     (wdat),
            .nxt       (slot_nxt[s])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.slots = slot_nxt;
        for (int p = 0; p < NUM_CORES; p++) begin
            st_d.rvld[p] = req_valid[p] && !req_write[p];
            st_d.rdat[p] = rd_hit[p] ? st_q.slots[pidx[p]] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slots <= '1;
            st_q.rvld  <= '0;
            st_q.rdat  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots_q   = st_q.slots;
    assign rsp_valid = st_q.rvld;
    for (genvar p = 0; p < NUM_CORES; p++) begin : g_out
        assign rsp_rdata[p] = st_q.rdat[p];
    end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_bank_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NUM_SEM   = 32,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h80
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_CORES-1:0]             req_valid,
    input logic [NUM_CORES-1:0]             req_write,
    input logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr,
    input logic [NUM_CORES-1:0][31:0]       req_wdata,
    input logic [NUM_CORES-1:0]             rsp_valid,
    input logic [NUM_CORES-1:0][31:0]       rsp_rdata,
    input word_t [NUM_SEM-1:0]              slots_q
);

    logic  [NUM_CORES-1:0] rd_hit_c, rd_miss_c, rd_any_c;
    word_t [NUM_CORES-1:0] cur_c;
    logic  [NUM_SEM-1:0]   any_rel, any_acq;
    word_t [NUM_SEM-1:0]   win_dat;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (32'(a) >= BASE_ADDR) && (32'(a) < BASE_ADDR + 4 * NUM_SEM) && (a[1:0] == 2'b00);
    endfunction

    function automatic int unsigned slot_of(input logic [ADDR_W-1:0] a);
        return (32'(a) - BASE_ADDR) >> 2;
    endfunction

    always_comb begin
        any_rel = '0;
        any_acq = '0;
        win_dat = '1;
        for (int p = 0; p < NUM_CORES; p++) begin
            rd_any_c[p]  = req_valid[p] && !req_write[p];
            rd_hit_c[p]  = rd_any_c[p] && in_window(req_addr[p]);
            rd_miss_c[p] = rd_any_c[p] && !in_window(req_addr[p]);
            cur_c[p]     = in_window(req_addr[p]) ? slots_q[slot_of(req_addr[p])] : '0;
        end
        for (int s = 0; s < NUM_SEM; s++) begin
            for (int p = NUM_CORES - 1; p >= 0; p--) begin
                if (req_valid[p] && req_write[p] && in_window(req_addr[p])
                    && slot_of(req_addr[p]) == s) begin
                    if (req_wdata[p] == FREE_VAL) begin
                        any_rel[s] = 1'b1;
                    end else begin
                        any_acq[s] = 1'b1;
                        win_dat[s] = req_wdata[p];
                    end
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_slot_chk
        assert_acquire_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[s] == FREE_VAL && any_acq[s]) |=> (slots_q[s] != FREE_VAL));
        assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[s] == FREE_VAL && any_acq[s]) |=> (slots_q[s] == $past(win_dat[s])));
        assert_held_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[s] != FREE_VAL && !any_rel[s]) |=> $stable(slots_q[s]));
        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[s] != FREE_VAL && any_rel[s]) |=> (slots_q[s] == FREE_VAL));
        assert_free_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[s] == FREE_VAL && !any_acq[s]) |=> (slots_q[s] == FREE_VAL));
    end

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port_chk
        assert_rsp_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_any_c[p] |=> rsp_valid[p]);
        assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_any_c[p] |=> !rsp_valid[p]);
        assert_read_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit_c[p] |=> (rsp_rdata[p] == $past(cur_c[p])));
        assert_read_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_miss_c[p] |=> (rsp_rdata[p] == '0));
    end

endmodule

bind sem_bank sem_bank_chk #(
    .NUM_CORES(NUM_CORES),
    .NUM_SEM  (NUM_SEM),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .slots_q  (slots_q)
);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;

    localparam int NC   = 4;
    localparam int NS   = 32;
    localparam int AW   = 16;
    localparam int BASE = 32'h80;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        req_valid = '0;
    logic [NC-1:0]        req_write = '0;
    logic [NC-1:0][AW-1:0] req_addr = '0;
    logic [NC-1:0][31:0]  req_wdata = '0;
    logic [NC-1:0]        rsp_valid;
    logic [NC-1:0][31:0]  rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [31:0] m [NS];

    always #2.5 clk = ~clk;

    sem_bank #(.NUM_CORES(NC), .NUM_SEM(NS), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL R9 watchdog expired actual=%0d cycles expected<=100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [AW-1:0] sem_addr(input int n);
        return AW'(BASE + 4 * n);
    endfunction

    function automatic bit in_win(input logic [AW-1:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + 4 * NS) && (a[1:0] == 2'b00);
    endfunction

    function automatic int slot_of(input logic [AW-1:0] a);
        return (int'(a) - BASE) / 4;
    endfunction

    task automatic check(input string tag, input int p, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s port %0d actual=%h expected=%h", tag, p, act, exp);
        end
    endtask

    task automatic clear_reqs();
        req_valid = '0;
        req_write = '0;
        req_addr  = '0;
        req_wdata = '0;
    endtask

    task automatic put_write(input int p, input logic [AW-1:0] a, input logic [31:0] d);
        req_valid[p] = 1'b1;
        req_write[p] = 1'b1;
        req_addr[p]  = a;
        req_wdata[p] = d;
    endtask

    task automatic put_read(input int p, input logic [AW-1:0] a);
        req_valid[p] = 1'b1;
        req_write[p] = 1'b0;
        req_addr[p]  = a;
    endtask

    // One clock: predict responses and next model state, then compare
    task automatic step(input string tag);
        logic        ev [NC];
        logic [31:0] ed [NC];
        logic [31:0] nm [NS];
        bit          done;
        for (int p = 0; p < NC; p++) begin
            ev[p] = req_valid[p] && !req_write[p];
            ed[p] = (ev[p] && in_win(req_addr[p])) ? m[slot_of(req_addr[p])] : 32'h0;
        end
        for (int s = 0; s < NS; s++) begin
            nm[s] = m[s];
            done  = 1'b0;
            for (int p = 0; p < NC; p++) begin
                if (req_valid[p] && req_write[p] && in_win(req_addr[p]) && slot_of(req_addr[p]) == s) begin
                    if (m[s] == ONES) begin
                        if (!done && req_wdata[p] != ONES) begin
                            nm[s] = req_wdata[p];
                            done  = 1'b1;
                        end
                    end else if (req_wdata[p] == ONES) begin
                        nm[s] = ONES;
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < NC; p++) begin
            check("R9 response strobe", p, {31'b0, rsp_valid[p]}, {31'b0, ev[p]});
            if (ev[p]) check(tag, p, rsp_rdata[p], ed[p]);
        end
        for (int s = 0; s < NS; s++) m[s] = nm[s];
        clear_reqs();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) m[s] = ONES;

        // R2: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset rsp_valid", 0, {28'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < NS / NC; k++) begin
            for (int p = 0; p < NC; p++) put_read(p, sem_addr(k * NC + p));
            step("R2 reset value");
        end

        // R3: lone acquire by port 2 on semaphore 5
        put_write(2, sem_addr(5), 32'd2);
        step("R3");
        put_read(0, sem_addr(5));
        step("R3 acquire readback");

        // R4: port 1 tries a held semaphore
        put_write(1, sem_addr(5), 32'd1);
        step("R4");
        put_read(1, sem_addr(5));
        step("R4 held write ignored");

        // R5: non-owner port 3 releases
        put_write(3, sem_addr(5), ONES);
        step("R5");
        put_read(2, sem_addr(5));
        step("R5 release by non-owner");

        // R6: three ports contend; same-cycle read sees old value (R1)
        put_write(3, sem_addr(9), 32'd3);
        put_write(1, sem_addr(9), 32'd1);
        put_write(2, sem_addr(9), 32'd2);
        put_read(0, sem_addr(9));
        step("R1 read before write");
        put_read(3, sem_addr(9));
        step("R6 lowest port wins");

        // R7: release and acquire collide on held semaphore 9
        put_write(0, sem_addr(9), ONES);
        put_write(2, sem_addr(9), 32'd2);
        step("R7");
        put_read(1, sem_addr(9));
        step("R7 release wins over acquire");

        // R8: accesses outside the window and unaligned
        put_write(0, AW'(BASE - 4), 32'd0);
        put_write(1, AW'(BASE + 4 * NS), 32'd1);
        put_write(2, AW'(BASE + 2), 32'd2);
        step("R8");
        put_read(0, AW'(BASE - 4));
        put_read(1, AW'(BASE + 4 * NS));
        put_read(2, AW'(BASE + 2));
        put_read(3, sem_addr(0));
        step("R8 out of window");

        // Random phase with contention on a few semaphores
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < NC; p++) begin
                if ($urandom_range(9) < 7) begin
                    logic [AW-1:0] a;
                    logic [31:0]   d;
                    int            r;
                    r = $urandom_range(99);
                    if (r < 60)      a = sem_addr($urandom_range(7));
                    else if (r < 85) a = sem_addr($urandom_range(NS - 1));
                    else             a = AW'($urandom_range(16'h1FF));
                    r = $urandom_range(9);
                    if (r < 4)      d = ONES;
                    else if (r < 8) d = 32'(p);
                    else            d = 32'($urandom_range(15));
                    if ($urandom_range(1) == 1) put_write(p, a, d);
                    else                        put_read(p, a);
                end
            end
            step("R1 random");
        end

        // Final sweep of all registers
        for (int k = 0; k < NS / NC; k++) begin
            for (int p = 0; p < NC; p++) put_read(p, sem_addr(k * NC + p));
            step("R1 final sweep");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule